// File: doc/BRIEF.md
# CAN Receive Queue with Foreground Buffer and Flags

This block sits between the receive side of a CAN controller and the host. Frames that the protocol engine has already checked arrive as opaque words. The block keeps them in a small queue. The oldest stored frame is presented to the host in a foreground buffer. The host tells the block it has finished with that frame by writing one to the receive-full flag. Only then does the next stored frame move forward.

Two level interrupts are produced. The receive interrupt follows the receive-full flag and the error interrupt follows the overrun flag, each gated by its own enable bit. The enable register is cleared and held cleared while the controller is in initialization mode. The block also reports the receiver and transmitter error levels. A transmitter that goes bus-off pulls the reported receiver level to bus-off as well. When the transmitter recovers, the receiver level drops straight to OK.

Top module: `canRxQueue`

## Requirements
- R1: A frame is stored only when `frameValid` and `frameOk` are both high in the same cycle. If the queue was empty, `flagReg[0]` (receive-full) reads 1 and `bufData` shows the frame two rising edges after that cycle.
- R2: While `flagReg[0]` is 1, the foreground frame on `bufData` does not change, whatever frames arrive.
- R3: Writing 1 to bit 0 of the flag register (`wrAddr`=0) while `flagReg[0]` is 1 releases the foreground frame. The next stored frame, if there is one, appears and sets `flagReg[0]` on the following edge. Writing 0 to that bit has no effect, and so does writing 1 while the flag is already 0.
- R4: The queue holds 5 frames, the foreground frame included. A good frame that arrives while 5 are held is discarded and sets `flagReg[1]` (overrun).
- R5: Writing 1 to bit 1 of the flag register clears the overrun flag. When an overrun occurs in the same cycle as that write, the flag stays set.
- R6: `rxIrq` equals `flagReg[0]` AND `enableReg[0]`, and `errIrq` equals `flagReg[1]` AND `enableReg[1]`.
- R7: The enable register (`wrAddr`=1) reads back on `enableReg`. Its bits are: 7 wakeup, 6 status change, 5:4 receiver level, 3:2 transmitter level, 1 overrun, 0 receive-full. A write takes effect only while `initReq` and `initAck` are both low.
- R8: While `initReq` and `initAck` are both high, `enableReg` is cleared on the next edge and stays 0.
- R9: `flagReg[5:4]` shows the receiver level and `flagReg[3:2]` shows the transmitter level, one edge after the inputs. The codes are 0 OK, 1 warning, 2 error and 3 bus-off. A level input of 3 is shown as 2. Initialization mode does not affect these fields, and `flagReg[7:6]` read 0.
- R10: When `txErrCnt` is above 255, both level fields read 3 on the next edge. At 255 the transmitter field follows `txLevel`.
- R11: On the first edge after bus-off ends, the receiver field reads 0 regardless of `rxLevel`. From the next edge on it follows `rxLevel` again.
- R12: `bufData` is 0 while `flagReg[0]` is 0. A `bufRead` in that state sets `accessErr`, which stays high until reset.
- R13: After reset, `flagReg`, `enableReg`, `bufData`, `rxIrq`, `errIrq` and `accessErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | A received frame is presented this cycle |
| frameOk | input | 1 | The presented frame passed identifier, CRC and error checks |
| frameData | input | DATA_W | Frame word |
| wrEn | input | 1 | Host register write strobe |
| wrAddr | input | 1 | 0 selects the flag register, 1 selects the enable register |
| wrData | input | 8 | Host write data |
| bufRead | input | 1 | Host reads the foreground buffer |
| bufData | output | DATA_W | Foreground frame, or 0 when empty |
| flagReg | output | 8 | Flags and error-level fields |
| enableReg | output | 8 | Interrupt enable register |
| initReq | input | 1 | Initialization request |
| initAck | input | 1 | Initialization acknowledge |
| rxLevel | input | 2 | Receiver error level |
| txLevel | input | 2 | Transmitter error level below bus-off |
| txErrCnt | input | ERRCNT_W | Transmit error count |
| rxIrq | output | 1 | Receive interrupt |
| errIrq | output | 1 | Error interrupt |
| accessErr | output | 1 | Sticky flag for a buffer read while empty |

## Verification
The hardest case to reach is an overrun that lands in the same cycle as a host write clearing the overrun flag. To get there, the queue has to be filled to exactly five frames while one frame waits unreleased in the foreground. The stimulus table fills and drains the queue step by step. A directed test then refills the queue to five, drives a good frame and the flag-clear write in one cycle, and confirms that the overrun flag and the error interrupt stay high. The bus-off recovery case is handled the same way: the receiver field is sampled on the exact edge after the error count falls back, while `rxLevel` is held at a nonzero value.

// File: rtl/canRxPkg.sv
package canRxPkg;
  typedef enum logic [1:0] {
    LVL_OK   = 2'd0,
    LVL_WARN = 2'd1,
    LVL_ERR  = 2'd2,
    LVL_OFF  = 2'd3
  } errLvl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

  localparam int BIT_RXF = 0;
  localparam int BIT_OVR = 1;
endpackage

// File: rtl/rxQueueData.sv
module rxQueueData
  import canRxPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  qStrobe_t          strb,
  input  logic              fgValid,
  input  logic [DATA_W-1:0] frameData,
  output logic [DATA_W-1:0] bufData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.push && wrPtr == PTR_W'(i)) mem[i] <= frameData;
    end
  end

  assign bufData = fgValid ? mem[rdPtr] : '0;

  // R4
  wr_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.push |=> $stable(wrPtr));

  // R3
  rd_ptr_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> !$stable(rdPtr));
endmodule

// File: rtl/rxQueueCtrl.sv
module rxQueueCtrl
  import canRxPkg::*;
#(
  parameter int DEPTH    = 5,
  parameter int ERRCNT_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameValid,
  input  logic                frameOk,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [7:0]          wrData,
  input  logic                bufRead,
  input  logic                initReq,
  input  logic                initAck,
  input  logic [1:0]          rxLevel,
  input  logic [1:0]          txLevel,
  input  logic [ERRCNT_W-1:0] txErrCnt,
  output qStrobe_t            strb,
  output logic                fgValid,
  output logic [7:0]          flagReg,
  output logic [7:0]          enableReg,
  output logic                rxIrq,
  output logic                errIrq,
  output logic                accessErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [ERRCNT_W-1:0] OFF_LIMIT = ERRCNT_W'(255);

  logic [CNT_W-1:0] count;
  logic             ovrFlag;
  errLvl_t          rxState, txState;

  logic frameGood, full, flagWr, enWr, release_, shift, initMode, busOff;

  assign frameGood = frameValid & frameOk;
  assign full      = (count == FULL_CNT);
  assign flagWr    = wrEn & ~wrAddr;
  assign enWr      = wrEn & wrAddr & ~initReq & ~initAck;
  assign release_  = flagWr & wrData[BIT_RXF] & fgValid;
  assign shift     = ~fgValid & (count != '0);
  assign initMode  = initReq & initAck;
  assign busOff    = txErrCnt > OFF_LIMIT;

  assign strb.push = frameGood & ~full;
  assign strb.pop  = release_;

  function automatic errLvl_t clampLvl(input logic [1:0] v);
    return (v == 2'd3) ? LVL_ERR : errLvl_t'(v);
  endfunction

  // occupancy and foreground state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      fgValid <= 1'b0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (release_)   fgValid <= 1'b0;
      else if (shift) fgValid <= 1'b1;
    end
  end

  // overrun flag: set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          ovrFlag <= 1'b0;
    else if (frameGood && full)         ovrFlag <= 1'b1;
    else if (flagWr && wrData[BIT_OVR]) ovrFlag <= 1'b0;
  end

  // enable register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         enableReg <= '0;
    else if (initMode) enableReg <= '0;
    else if (enWr)     enableReg <= wrData;
  end

  // error-level tracking with bus-off coupling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= LVL_OK;
      txState <= LVL_OK;
    end else if (busOff) begin
      rxState <= LVL_OFF;
      txState <= LVL_OFF;
    end else begin
      txState <= clampLvl(txLevel);
      rxState <= (txState == LVL_OFF) ? LVL_OK : clampLvl(rxLevel);
    end
  end

  // sticky access error
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   accessErr <= 1'b0;
    else if (bufRead && !fgValid) accessErr <= 1'b1;
  end

  assign flagReg = {2'b00, rxState, txState, ovrFlag, fgValid};
  assign rxIrq   = fgValid & enableReg[BIT_RXF];
  assign errIrq  = ovrFlag & enableReg[BIT_OVR];

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameGood && full) |=> flagReg[BIT_OVR]);

  // R3
  shift_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fgValid) |-> $past(count) != '0);

  // R8
  init_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    initMode |=> enableReg == 8'h00);

  // R10
  bus_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOff |=> (flagReg[5:4] == 2'd3 && flagReg[3:2] == 2'd3));

  // R11
  recover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg[3:2] == 2'd3 && !busOff) |=> flagReg[5:4] == 2'd0);

  // R12
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |=> accessErr);
endmodule

// File: rtl/canRxQueue.sv
module canRxQueue
  import canRxPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 5,
  parameter int ERRCNT_W = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameValid,
  input  logic                frameOk,
  input  logic [DATA_W-1:0]   frameData,
  input  logic                wrEn,
  input  logic                wrAddr,
  input  logic [7:0]          wrData,
  input  logic                bufRead,
  output logic [DATA_W-1:0]   bufData,
  output logic [7:0]          flagReg,
  output logic [7:0]          enableReg,
  input  logic                initReq,
  input  logic                initAck,
  input  logic [1:0]          rxLevel,
  input  logic [1:0]          txLevel,
  input  logic [ERRCNT_W-1:0] txErrCnt,
  output logic                rxIrq,
  output logic                errIrq,
  output logic                accessErr
);
  qStrobe_t strb;
  logic     fgValid;

  rxQueueCtrl #(.DEPTH(DEPTH), .ERRCNT_W(ERRCNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .frameValid(frameValid), .frameOk(frameOk),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .bufRead(bufRead), .initReq(initReq), .initAck(initAck),
    .rxLevel(rxLevel), .txLevel(txLevel), .txErrCnt(txErrCnt),
    .strb(strb), .fgValid(fgValid),
    .flagReg(flagReg), .enableReg(enableReg),
    .rxIrq(rxIrq), .errIrq(errIrq), .accessErr(accessErr)
  );

  rxQueueData #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_data (
    .clk(clk), .rstN(rstN),
    .strb(strb), .fgValid(fgValid),
    .frameData(frameData), .bufData(bufData)
  );
endmodule

// File: tb/test_canRxQueue.sv
`timescale 1ns/1ps
module test_canRxQueue;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 0, frameOk = 0;
  logic [31:0] frameData = '0;
  logic        wrEn = 0, wrAddr = 0;
  logic [7:0]  wrData = '0;
  logic        bufRead = 0;
  logic [31:0] bufData;
  logic [7:0]  flagReg, enableReg;
  logic        initReq = 0, initAck = 0;
  logic [1:0]  rxLevel = 0, txLevel = 0;
  logic [8:0]  txErrCnt = '0;
  logic        rxIrq, errIrq, accessErr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  canRxQueue i_canRxQueue (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameOk(frameOk),
    .frameData(frameData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .bufRead(bufRead), .bufData(bufData), .flagReg(flagReg),
    .enableReg(enableReg), .initReq(initReq), .initAck(initAck),
    .rxLevel(rxLevel), .txLevel(txLevel), .txErrCnt(txErrCnt),
    .rxIrq(rxIrq), .errIrq(errIrq), .accessErr(accessErr)
  );

  // op: 0 good frame, 1 bad frame, 2 release, 3 idle, 4 clear overrun
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] d;
    logic        rxf;
    logic        ovr;
    logic [31:0] expBuf;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{3'd0, 32'hA000_0001, 1'b1, 1'b0, 32'hA000_0001},
    '{3'd1, 32'hBBBB_0002, 1'b1, 1'b0, 32'hA000_0001},
    '{3'd0, 32'hA000_0003, 1'b1, 1'b0, 32'hA000_0001},
    '{3'd0, 32'hA000_0004, 1'b1, 1'b0, 32'hA000_0001},
    '{3'd0, 32'hA000_0005, 1'b1, 1'b0, 32'hA000_0001},
    '{3'd0, 32'hA000_0006, 1'b1, 1'b0, 32'hA000_0001},
    '{3'd0, 32'hA000_0007, 1'b1, 1'b1, 32'hA000_0001},
    '{3'd2, 32'h0,         1'b1, 1'b1, 32'hA000_0003},
    '{3'd2, 32'h0,         1'b1, 1'b1, 32'hA000_0004},
    '{3'd2, 32'h0,         1'b1, 1'b1, 32'hA000_0005},
    '{3'd2, 32'h0,         1'b1, 1'b1, 32'hA000_0006},
    '{3'd2, 32'h0,         1'b0, 1'b1, 32'h0},
    '{3'd2, 32'h0,         1'b0, 1'b1, 32'h0},
    '{3'd4, 32'h0,         1'b0, 1'b0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    frameValid = 0; frameOk = 0; wrEn = 0; wrAddr = 0; wrData = '0; bufRead = 0;
  endtask

  // drive for one cycle, then let one more edge pass; returns at a negedge
  task automatic doOp(input logic [2:0] op, input logic [31:0] d);
    @(negedge clk);
    case (op)
      3'd0: begin frameValid = 1; frameOk = 1; frameData = d; end
      3'd1: begin frameValid = 1; frameOk = 0; frameData = d; end
      3'd2: begin wrEn = 1; wrAddr = 0; wrData = 8'h01; end
      3'd4: begin wrEn = 1; wrAddr = 0; wrData = 8'h02; end
      default: ;
    endcase
    @(negedge clk);
    idleInputs();
    @(negedge clk);
  endtask

  task automatic regWrite(input logic a, input logic [7:0] v);
    @(negedge clk);
    wrEn = 1; wrAddr = a; wrData = v;
    @(negedge clk);
    idleInputs();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    check("R13 flags", flagReg, 8'h00);
    check("R13 enable", enableReg, 8'h00);
    check("R13 irqs", {rxIrq, errIrq, accessErr}, 3'b000);
    check("R13 buf", bufData, 32'h0);

    // table: fill, overrun, drain
    foreach (VEC[i]) begin
      doOp(VEC[i].op, VEC[i].d);
      check($sformatf("R1 R3 rxf step %0d", i), flagReg[0], VEC[i].rxf);
      check($sformatf("R4 R5 ovr step %0d", i), flagReg[1], VEC[i].ovr);
      check($sformatf("R2 buf step %0d", i), bufData, VEC[i].expBuf);
    end

    // R12 empty read
    @(negedge clk);
    bufRead = 1;
    #1 check("R12 buf zero when empty", bufData, 32'h0);
    @(negedge clk);
    bufRead = 0;
    check("R12 accessErr set", accessErr, 1'b1);
    repeat (3) @(negedge clk);
    check("R12 accessErr sticky", accessErr, 1'b1);

    // R7 enable write, R6 interrupts
    regWrite(1'b1, 8'h03);
    check("R7 enable readback", enableReg, 8'h03);
    check("R6 rxIrq idle", rxIrq, 1'b0);
    doOp(3'd0, 32'hC000_0001);
    check("R6 rxIrq on frame", rxIrq, 1'b1);
    check("R6 errIrq none", errIrq, 1'b0);

    // R3 zero write no effect
    doOp(3'd3, 32'h0);
    regWrite(1'b0, 8'h00);
    @(negedge clk);
    check("R3 zero write keeps rxf", flagReg[0], 1'b1);
    check("R3 zero write keeps buf", bufData, 32'hC000_0001);

    // R5 fill to five, then overrun with simultaneous clear
    for (int k = 2; k <= 5; k++) doOp(3'd0, 32'hC000_0000 + k);
    check("R4 no overrun at five", flagReg[1], 1'b0);
    @(negedge clk);
    frameValid = 1; frameOk = 1; frameData = 32'hDEAD_0006;
    wrEn = 1; wrAddr = 0; wrData = 8'h02;
    @(negedge clk);
    idleInputs();
    check("R5 set wins over clear", flagReg[1], 1'b1);
    check("R6 errIrq on overrun", errIrq, 1'b1);
    regWrite(1'b0, 8'h02);
    check("R5 clear overrun", flagReg[1], 1'b0);
    check("R2 buf held", bufData, 32'hC000_0001);

    // R8 init mode, R9 levels unaffected
    @(negedge clk);
    initReq = 1; initAck = 1; rxLevel = 2; txLevel = 1;
    @(negedge clk);
    check("R8 enable cleared", enableReg, 8'h00);
    regWrite(1'b1, 8'hFF);
    check("R8 write ignored in init", enableReg, 8'h00);
    check("R9 levels during init", flagReg[5:2], 4'b1001);
    initAck = 0;
    regWrite(1'b1, 8'h0F);
    check("R7 write ignored with initReq", enableReg, 8'h00);
    initReq = 0;
    regWrite(1'b1, 8'hA5);
    check("R7 write accepted", enableReg, 8'hA5);
    check("R6 rxIrq bit0", rxIrq, 1'b1);
    check("R6 errIrq bit1 clear", errIrq, 1'b0);

    // R10 bus-off threshold
    @(negedge clk);
    txErrCnt = 9'd255;
    @(negedge clk);
    check("R10 at 255 tx follows input", flagReg[3:2], 2'd1);
    txErrCnt = 9'd256;
    @(negedge clk);
    check("R10 bus-off rx", flagReg[5:4], 2'd3);
    check("R10 bus-off tx", flagReg[3:2], 2'd3);

    // R11 recovery
    txErrCnt = 9'd0;
    @(negedge clk);
    check("R11 rx forced ok", flagReg[5:4], 2'd0);
    check("R11 tx follows", flagReg[3:2], 2'd1);
    @(negedge clk);
    check("R11 rx follows again", flagReg[5:4], 2'd2);

    // R9 plain levels
    rxLevel = 1; txLevel = 2;
    @(negedge clk);
    check("R9 level fields", flagReg[7:2], 6'b000110);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule